// File: doc/BRIEF.md
# Store set identifier table

This block is the history half of a memory dependence predictor. It is a direct-mapped table with no tags, addressed by the index field of an instruction's PC. Every entry holds a valid flag and a small store set identifier. When a load or store is fetched, its entry is looked up. A valid entry names the store set that the instruction belongs to. An invalid entry means the instruction has no store set, so no dependence is predicted for it. Two different PCs that share an index share an entry. Nothing checks for this.

When the pipeline reports a memory-order violation, it gives the index of the load and the index of the store involved. The table then joins the two instructions into one store set:
- If neither has an identifier, a fresh one is made by hashing the load index, and both entries get it.
- If only one has an identifier, the other adopts it.
- If both have identifiers and they differ, the smaller number wins and the other entry is rewritten with it.

A store entry holds a single identifier, so a store is in at most one set at any time.

Links learned long ago can go stale. To let the table retrain, a free-running interval counter starts a sweep once per interval. The sweep clears one entry per cycle, from index zero upward, until it reaches the top. Pipeline recovery (branch, jump or ordering flushes) does not touch the table at all. For this reason the block has no recovery input.

Top module: `ssid_table`

## Requirements
- R1: A lookup request in one cycle gives its result one cycle later. The result reflects the table contents before any update made on the same clock edge.
- R2: After reset every entry is invalid. A lookup that lands on an invalid entry reports a miss (hit 0) with an identifier of 0.
- R3: A violation where neither entry is valid writes both entries valid with the identifier formed by XOR-ing together consecutive ID_W-bit slices of the load index. The lowest slice comes first and the top slice is zero-padded.
- R4: A violation where exactly one of the two entries is valid copies that entry's identifier into the other entry and leaves the valid entry as it is.
- R5: A violation where both entries are valid with different identifiers rewrites only the entry holding the larger identifier, using the smaller one. If the identifiers are equal, nothing is written. No entry outside the two indexed ones changes.
- R6: The interval counter starts with reset and wraps every INTERVAL cycles. After the Nth clock edge following reset release, entry j is cleared on edge N = k*INTERVAL + 1 + j, for k = 1, 2, …, one entry per edge in ascending order.
- R7: A violation write to an index on the same edge that the sweep clears that index leaves the entry valid, holding the written identifier.
- R8: lk_valid is high in exactly the cycle after a cycle with lk_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request for a fetched load or store |
| lk_idx | input | IDX_W | PC index field of the looked-up instruction |
| lk_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Entry was valid (instruction belongs to a store set) |
| lk_ssid | output | ID_W | Store set identifier, zero on a miss |
| vio_req | input | 1 | Memory-order violation report |
| vio_ld_idx | input | IDX_W | PC index field of the violating load |
| vio_st_idx | input | IDX_W | PC index field of the violating store |

## Verification
The hardest situation to create is a violation write that lands on the very index the sweep is clearing on the same edge. A second hard one is a both-valid merge where the loser's entry is about to be swept. The sweep position is not visible at the ports, so the bench counts clock edges from reset release and predicts the clear edge of each entry from R6. It then fires a violation on exactly the clear edge of the store's entry, with a load whose trained identifier is smaller. Lookups issued one edge on either side of the clear edges confirm where the sweep stands. They also show that only the prioritized entry survives the pass.

// File: rtl/ssid_pkg.sv
package ssid_pkg;

  // Outcome of a violation merge decision
  typedef enum logic [2:0] {
    MG_NONE,      // no violation this cycle
    MG_ALLOC,     // both invalid: fresh identifier into both entries
    MG_LD_TAKES,  // only the store valid: load entry adopts it
    MG_ST_TAKES,  // only the load valid: store entry adopts it
    MG_LD_LOSES,  // both valid, store id smaller: load entry rewritten
    MG_ST_LOSES,  // both valid, load id smaller: store entry rewritten
    MG_SAME       // both valid, equal ids: nothing to do
  } merge_kind_e;

  typedef enum logic {
    SW_IDLE,
    SW_RUN
  } sweep_state_e;

endpackage

// File: rtl/ssid_merge.sv
module ssid_merge
  import ssid_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int ID_W  = 7
) (
  input  logic             fire,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_v,
  input  logic [ID_W-1:0]  ld_id,
  input  logic             st_v,
  input  logic [ID_W-1:0]  st_id,
  output merge_kind_e      kind,
  output logic             wr_ld,
  output logic             wr_st,
  output logic [ID_W-1:0]  wr_id
);

  localparam int SLICES = (IDX_W + ID_W - 1) / ID_W;
  localparam int PAD_W  = SLICES * ID_W;

  // XOR fold of the load index into an identifier
  function automatic logic [ID_W-1:0] fold_hash(input logic [IDX_W-1:0] idx);
    logic [PAD_W-1:0] padded;
    logic [ID_W-1:0]  acc;
    padded = PAD_W'(idx);
    acc    = '0;
    for (int s = 0; s < SLICES; s++) begin
      acc = acc ^ padded[s*ID_W +: ID_W];
    end
    return acc;
  endfunction

  function automatic merge_kind_e classify(input logic f, input logic lv, input logic sv,
                                           input logic [ID_W-1:0] li,
                                           input logic [ID_W-1:0] si);
    if (!f)                  return MG_NONE;
    else if (!lv && !sv)     return MG_ALLOC;
    else if (lv && !sv)      return MG_ST_TAKES;
    else if (!lv && sv)      return MG_LD_TAKES;
    else if (li < si)        return MG_ST_LOSES;
    else if (si < li)        return MG_LD_LOSES;
    else                     return MG_SAME;
  endfunction

  always_comb begin
    kind  = classify(fire, ld_v, st_v, ld_id, st_id);
    wr_ld = 1'b0;
    wr_st = 1'b0;
    wr_id = '0;
    unique case (kind)
      MG_ALLOC: begin
        wr_ld = 1'b1;
        wr_st = 1'b1;
        wr_id = fold_hash(ld_idx);
      end
      MG_ST_TAKES, MG_ST_LOSES: begin
        wr_st = 1'b1;
        wr_id = ld_id;
      end
      MG_LD_TAKES, MG_LD_LOSES: begin
        wr_ld = 1'b1;
        wr_id = st_id;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ssid_sweep.sv
module ssid_sweep
  import ssid_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int INTERVAL = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] interval_cnt;
  logic [IDX_W-1:0] ptr;
  sweep_state_e     state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      interval_cnt <= '0;
      ptr          <= '0;
      state        <= SW_IDLE;
    end else begin
      interval_cnt <= (interval_cnt == CNT_LAST) ? '0 : interval_cnt + 1'b1;
      if (state == SW_RUN) begin
        ptr <= ptr + 1'b1;
        if (ptr == IDX_LAST) state <= SW_IDLE;
      end
      if (interval_cnt == CNT_LAST) begin
        state <= SW_RUN;
        ptr   <= '0;
      end
    end
  end

  assign clr_en  = (state == SW_RUN);
  assign clr_idx = ptr;

endmodule

// File: rtl/ssid_array.sv
module ssid_array #(
  parameter int IDX_W    = 12,
  parameter int ID_W     = 7,
  parameter int RD_PORTS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [ID_W-1:0]  w_id,
  input  logic [IDX_W-1:0] rd_idx [RD_PORTS],
  output logic             rd_v   [RD_PORTS],
  output logic [ID_W-1:0]  rd_id  [RD_PORTS]
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld;
  logic [ID_W-1:0]  ids [DEPTH];

  // Later nonblocking writes win: violation writes override the sweep clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (clr_en) vld[clr_idx] <= 1'b0;
      if (wa_en)  vld[wa_idx]  <= 1'b1;
      if (wb_en)  vld[wb_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) ids[wa_idx] <= w_id;
    if (wb_en) ids[wb_idx] <= w_id;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_v[p]  = vld[rd_idx[p]];
    assign rd_id[p] = ids[rd_idx[p]];
  end

endmodule

// File: rtl/ssid_table.sv
module ssid_table
  import ssid_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int ID_W     = 7,
  parameter int INTERVAL = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_hit,
  output logic [ID_W-1:0]  lk_ssid,
  input  logic             vio_req,
  input  logic [IDX_W-1:0] vio_ld_idx,
  input  logic [IDX_W-1:0] vio_st_idx
);

  localparam int RD_LK = 0;
  localparam int RD_LD = 1;
  localparam int RD_ST = 2;
  localparam int NRD   = 3;

  logic [IDX_W-1:0] rd_idx [NRD];
  logic             rd_v   [NRD];
  logic [ID_W-1:0]  rd_id  [NRD];

  // Named internal events for the checker
  logic             vio_fire;
  logic             ld_v, st_v;
  logic [ID_W-1:0]  ld_id, st_id;
  merge_kind_e      mg_kind;
  logic             wr_ld, wr_st;
  logic [ID_W-1:0]  wr_id;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;

  assign rd_idx[RD_LK] = lk_idx;
  assign rd_idx[RD_LD] = vio_ld_idx;
  assign rd_idx[RD_ST] = vio_st_idx;

  assign vio_fire = vio_req;
  assign ld_v     = rd_v[RD_LD];
  assign st_v     = rd_v[RD_ST];
  assign ld_id    = rd_id[RD_LD];
  assign st_id    = rd_id[RD_ST];

  ssid_merge #(.IDX_W(IDX_W), .ID_W(ID_W)) u_merge (
    .fire   (vio_fire),
    .ld_idx (vio_ld_idx),
    .ld_v   (ld_v),
    .ld_id  (ld_id),
    .st_v   (st_v),
    .st_id  (st_id),
    .kind   (mg_kind),
    .wr_ld  (wr_ld),
    .wr_st  (wr_st),
    .wr_id  (wr_id)
  );

  ssid_sweep #(.IDX_W(IDX_W), .INTERVAL(INTERVAL)) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

  ssid_array #(.IDX_W(IDX_W), .ID_W(ID_W), .RD_PORTS(NRD)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .wa_en   (wr_ld),
    .wa_idx  (vio_ld_idx),
    .wb_en   (wr_st),
    .wb_idx  (vio_st_idx),
    .w_id    (wr_id),
    .rd_idx  (rd_idx),
    .rd_v    (rd_v),
    .rd_id   (rd_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_hit   <= 1'b0;
      lk_ssid  <= '0;
    end else begin
      lk_valid <= lk_req;
      lk_hit   <= lk_req && rd_v[RD_LK];
      lk_ssid  <= (lk_req && rd_v[RD_LK]) ? rd_id[RD_LK] : '0;
    end
  end

endmodule

// File: rtl/ssid_table_chk.sv
module ssid_table_chk #(
  parameter int IDX_W = 12,
  parameter int ID_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic [ID_W-1:0]  lk_ssid,
  input logic             vio_fire,
  input logic             ld_v,
  input logic             st_v,
  input logic [ID_W-1:0]  ld_id,
  input logic [ID_W-1:0]  st_id,
  input logic             wr_ld,
  input logic             wr_st,
  input logic [ID_W-1:0]  wr_id,
  input logic             clr_en,
  input logic [IDX_W-1:0] clr_idx
);

  localparam logic [IDX_W-1:0] IDX_TOP = {IDX_W{1'b1}};

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_valid);
  a_r8_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_valid);
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ssid == '0));
  a_r3_alloc_both: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_fire && !ld_v && !st_v) |-> (wr_ld && wr_st));
  a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ld || wr_st) |-> vio_fire);
  a_r4_store_adopts: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_fire && ld_v && !st_v) |-> (wr_st && !wr_ld && wr_id == ld_id));
  a_r4_load_adopts: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_fire && !ld_v && st_v) |-> (wr_ld && !wr_st && wr_id == st_id));
  a_r5_min_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_fire && ld_v && st_v && ld_id != st_id) |->
      ($countones({wr_ld, wr_st}) == 1 && wr_id == ((ld_id < st_id) ? ld_id : st_id)));
  a_r5_equal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vio_fire && ld_v && st_v && ld_id == st_id) |-> (!wr_ld && !wr_st));
  a_r6_sweep_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_en) |-> (clr_idx == '0));
  a_r6_sweep_walks: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_idx != IDX_TOP) |=>
      (clr_en && clr_idx == IDX_W'($past(clr_idx) + 1'b1)));

endmodule

bind ssid_table ssid_table_chk #(.IDX_W(IDX_W), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_req   (lk_req),
  .lk_valid (lk_valid),
  .lk_hit   (lk_hit),
  .lk_ssid  (lk_ssid),
  .vio_fire (vio_fire),
  .ld_v     (ld_v),
  .st_v     (st_v),
  .ld_id    (ld_id),
  .st_id    (st_id),
  .wr_ld    (wr_ld),
  .wr_st    (wr_st),
  .wr_id    (wr_id),
  .clr_en   (clr_en),
  .clr_idx  (clr_idx)
);

// File: tb/ssid_table_test.sv
`timescale 1ns/1ps
module ssid_table_test;

  localparam int IDX_W    = 5;
  localparam int ID_W     = 3;
  localparam int INTERVAL = 400;
  localparam int DEPTH    = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_req = 1'b0;
  logic [IDX_W-1:0] lk_idx = '0;
  logic             lk_valid, lk_hit;
  logic [ID_W-1:0]  lk_ssid;
  logic             vio_req = 1'b0;
  logic [IDX_W-1:0] vio_ld_idx = '0;
  logic [IDX_W-1:0] vio_st_idx = '0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  bit exp_v  [DEPTH];
  int exp_id [DEPTH];

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  ssid_table #(.IDX_W(IDX_W), .ID_W(ID_W), .INTERVAL(INTERVAL)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_idx(lk_idx),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_ssid(lk_ssid),
    .vio_req(vio_req), .vio_ld_idx(vio_ld_idx), .vio_st_idx(vio_st_idx)
  );

  // Low three bits XOR the upper two bits (ID_W = 3, IDX_W = 5)
  function automatic int ref_hash(input int idx);
    return (idx % 8) ^ (idx / 8);
  endfunction

  // Reference merge, applied to the bench model
  function automatic void model_vio(input int ld, input int st);
    bit lv = exp_v[ld];
    bit sv = exp_v[st];
    int li = exp_id[ld];
    int si = exp_id[st];
    if (!lv && !sv) begin
      exp_v[ld] = 1; exp_id[ld] = ref_hash(ld);
      exp_v[st] = 1; exp_id[st] = ref_hash(ld);
    end else if (!sv) begin
      exp_v[st] = 1; exp_id[st] = li;
    end else if (!lv) begin
      exp_v[ld] = 1; exp_id[ld] = si;
    end else if (li > si) begin
      exp_id[ld] = si;
    end else if (si > li) begin
      exp_id[st] = li;
    end
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Drive at the current falling edge, sample at the next one
  task automatic step(input bit v, input int ld, input int st, input bit l, input int li);
    vio_req    = v;
    vio_ld_idx = IDX_W'(ld);
    vio_st_idx = IDX_W'(st);
    lk_req     = l;
    lk_idx     = IDX_W'(li);
    @(negedge clk);
    vio_req = 1'b0;
    lk_req  = 1'b0;
  endtask

  task automatic look_expect(input string tag, input int idx, input bit eh, input int eid);
    step(1'b0, 0, 0, 1'b1, idx);
    check(tag, lk_valid == 1'b1, $sformatf("valid idx %0d", idx), lk_valid, 1);
    check(tag, lk_hit == eh, $sformatf("hit idx %0d", idx), lk_hit, eh);
    check(tag, int'(lk_ssid) == (eh ? eid : 0), $sformatf("ssid idx %0d", idx),
          lk_ssid, eh ? eid : 0);
  endtask

  task automatic look_model(input string tag, input int idx);
    look_expect(tag, idx, exp_v[idx], exp_id[idx]);
  endtask

  task automatic viol(input int ld, input int st);
    step(1'b1, ld, st, 1'b0, 0);
    model_vio(ld, st);
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin exp_v[i] = 0; exp_id[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2 / R8: reset outputs
    check("R8", lk_valid == 1'b0, "valid after reset", lk_valid, 0);
    check("R2", lk_hit == 1'b0, "hit after reset", lk_hit, 0);
    check("R2", lk_ssid == '0, "ssid after reset", lk_ssid, 0);
    for (int j = 0; j < DEPTH; j++) look_expect("R2", j, 1'b0, 0);

    // R1: lookup in the same cycle as the allocating violation sees old state
    step(1'b1, 3, 9, 1'b1, 3);
    check("R1", lk_hit == 1'b0, "same-edge lookup", lk_hit, 0);
    model_vio(3, 9);
    look_expect("R3", 3, 1'b1, 3);
    look_expect("R3", 9, 1'b1, 3);
    // R8: no request, no valid
    step(1'b0, 0, 0, 1'b0, 0);
    check("R8", lk_valid == 1'b0, "valid without request", lk_valid, 0);

    viol(22, 1);                 // R3 with upper index bits set
    look_expect("R3", 22, 1'b1, 4);
    look_expect("R3", 1, 1'b1, 4);
    viol(3, 12);                 // R4: store adopts
    look_expect("R4", 12, 1'b1, 3);
    look_model("R4", 3);
    viol(17, 9);                 // R4: load adopts
    look_expect("R4", 17, 1'b1, 3);
    look_model("R4", 9);
    viol(30, 31);                // R3 allocation id 5
    look_expect("R3", 30, 1'b1, 5);
    viol(30, 9);                 // R5: store id smaller, load rewritten
    look_expect("R5", 30, 1'b1, 3);
    look_expect("R5", 31, 1'b1, 5);
    look_model("R5", 9);
    viol(3, 31);                 // R5: load id smaller, store rewritten
    look_expect("R5", 31, 1'b1, 3);
    look_model("R5", 3);
    viol(22, 1);                 // R5: equal ids, no change
    look_expect("R5", 22, 1'b1, 4);
    look_expect("R5", 1, 1'b1, 4);

    // Train every entry, then compare the whole table
    for (int j = 0; j < DEPTH; j++) viol(j, j);
    for (int j = 0; j < DEPTH; j++) look_model("R5", j);

    // R6: sweep begins; entry j cleared on edge INTERVAL+1+j
    wait_until(INTERVAL);
    look_expect("R6", 0, 1'b1, 0);        // reads state after edge 400
    look_expect("R6", 0, 1'b0, 0);        // reads after edge 401
    wait_until(INTERVAL + 5);
    look_expect("R6", 5, 1'b1, 5);        // after edge 405, not yet cleared
    look_expect("R6", 5, 1'b0, 0);        // after edge 406, cleared
    // R7: violation on the clear edge of entry 20 (edge 421)
    wait_until(INTERVAL + 20);
    step(1'b1, 25, 20, 1'b0, 0);          // 25 holds 2, 20 holds 6
    look_expect("R7", 20, 1'b1, 2);
    look_expect("R6", 19, 1'b0, 0);
    look_expect("R6", 31, 1'b1, 3);
    look_expect("R6", 25, 1'b1, 2);
    // After the pass only entry 20 survives
    for (int j = 0; j < DEPTH; j++) begin exp_v[j] = 0; exp_id[j] = 0; end
    exp_v[20] = 1; exp_id[20] = 2;
    wait_until(INTERVAL + DEPTH + 8);
    for (int j = 0; j < DEPTH; j++) look_model("R6", j);
    // Second pass clears entry 20
    wait_until(2 * INTERVAL + DEPTH + 8);
    look_expect("R6", 20, 1'b0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule